// File: doc/BRIEF.md
# Hit Event Framer with Ring Buffer Writer

This block turns a stream of pixel hit records into framed events and writes them, one 32-bit word per cycle, into an on-chip ring-buffer RAM. A frame opens with a fixed header word and a running event number. Each hit in the frame becomes one tagged word holding its column, row and timestamp. A fixed trailer word closes the frame.

The write address runs through the whole RAM and wraps back to zero. A status output gives the RAM address of the header of the most recently closed event, so a reader never follows a pointer into an event that is still being written. A synchronous clear restarts the buffer and the event count.

A separate Gray-coded timestamp counter is driven towards the sensor. Its step rate can be chosen at run time as one step every 1, 2, 4 or 8 clock cycles.

Top module: `hit_event_framer`

## Requirements
- R1: While reset is held and on the first cycle after it, `wr_en` is 0, `last_ptr` is 0 and `ts_gray` is 0.
- R2: When `ev_start` is seen with no event open, the next cycle shows a write of the header word 0xFABEABBA.
- R3: The write after a header carries the event number. The first event after reset or clear is number 0, and the number rises by one for each closed event, wrapping modulo 2^32.
- R4: While an event is open, a cycle with `hit_valid` shows a write on the next cycle of the hit word. Its layout is: bits 31..20 = 0xF0F, bits 19..14 = column, bits 13..8 = row, bits 7..0 = timestamp.
- R5: While an event is open, `ev_end` gives a write of the trailer word 0xBEEFBEEF on the next cycle. If `hit_valid` is seen in the same cycle, the trailer is written and that hit is dropped.
- R6: Writes use consecutive addresses. After address 2^ADDR_W-1 the next write goes to address 0.
- R7: `last_ptr` changes to the header address of an event on the same cycle as that event's trailer write appears on the port. At all other times it holds its value.
- R8: The following inputs cause no write: `hit_valid` or `ev_end` with no event open, any input in the cycle after a header is accepted, and `ev_start` while an event is open.
- R9: `clr` takes priority over all other inputs. It causes no write, closes any open event without a trailer, sends the next write to address 0, makes the next event number 0, and leaves `last_ptr` unchanged.
- R10: `ts_gray` equals bin XOR (bin >> 1), where bin counts up once every 2^`rate_sel` cycles. Two successive values never differ in more than one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous restart of write pointer, event count and framer |
| ev_start | input | 1 | Open a new event |
| ev_end | input | 1 | Close the open event |
| hit_valid | input | 1 | A hit record is present |
| hit_col | input | 6 | Hit column |
| hit_row | input | 6 | Hit row |
| hit_ts | input | 8 | Hit timestamp |
| rate_sel | input | 2 | Timestamp step: once every 2^rate_sel cycles |
| wr_en | output | 1 | RAM write enable |
| wr_addr | output | 16 | RAM write address |
| wr_data | output | 32 | RAM write data |
| last_ptr | output | 16 | Header address of the last closed event |
| ts_gray | output | 8 | Gray-coded timestamp |

## Verification
Every framing result, including the write enable, address, data word and the `last_ptr` update, appears exactly one cycle after the edge that samples the input that causes it. The bench drives inputs on a falling edge and samples on the next falling edge, so each stimulus row is compared against the register stage it feeds. The Gray output is combinational from its counter. After reset is released, it is sampled on each falling edge and compared with the Gray code of the number of rising edges seen so far. At the slower rate, the bench counts the changes over a window of sixteen cycles.

// File: rtl/evfr_pkg.sv
package evfr_pkg;
   localparam int          WORD_W   = 32;
   localparam int          TAG_W    = 12;
   localparam logic [31:0] HDR_WORD = 32'hFABE_ABBA;
   localparam logic [31:0] TRL_WORD = 32'hBEEF_BEEF;
   localparam logic [11:0] HIT_TAG  = 12'hF0F;

   typedef enum logic [1:0] {ST_IDLE, ST_NUM, ST_BODY} fr_state_t;
   typedef enum logic [1:0] {W_HDR, W_NUM, W_HIT, W_TRL} wsel_t;
endpackage

// File: rtl/evfr_gray_stamp.sv
module evfr_gray_stamp #(
   parameter int STAMP_W = 8,
   parameter int RATE_W  = 2,
   parameter bit REG_OUT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATE_W-1:0]  rate_sel,
   output logic [STAMP_W-1:0] gray_o
);
   localparam int PRE_W = ((1 << RATE_W) > 1) ? (1 << RATE_W) - 1 : 1;

   if (STAMP_W < 2) begin : g_bad_stamp
      $error("evfr_gray_stamp: STAMP_W must be at least 2");
   end
   if (RATE_W < 1 || RATE_W > 4) begin : g_bad_rate
      $error("evfr_gray_stamp: RATE_W must be 1..4");
   end

   logic [PRE_W-1:0]   pre;
   logic [PRE_W-1:0]   mask;
   logic               tick;
   logic [STAMP_W-1:0] bin;
   logic [STAMP_W-1:0] bin_nx;

   always_comb begin
      mask   = PRE_W'((32'd1 << rate_sel) - 32'd1);
      tick   = (pre & mask) == mask;
      bin_nx = tick ? bin + STAMP_W'(1) : bin;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre <= '0;
         bin <= '0;
      end else begin
         pre <= pre + PRE_W'(1);
         bin <= bin_nx;
      end
   end

   if (REG_OUT) begin : g_reg_out
      logic [STAMP_W-1:0] gray_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) gray_q <= '0;
         else        gray_q <= bin_nx ^ (bin_nx >> 1);
      end
      assign gray_o = gray_q;
   end else begin : g_comb_out
      assign gray_o = bin ^ (bin >> 1);
   end

   // R10: successive timestamps differ in at most one bit
   p_gray_onebit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(gray_o ^ $past(gray_o)) <= 1));
   // R10: no step without a rate tick
   p_gray_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(gray_o));
endmodule

// File: rtl/evfr_frame_ctl.sv
module evfr_frame_ctl
   import evfr_pkg::*;
#(
   parameter int COL_W = 6,
   parameter int ROW_W = 6,
   parameter int TS_W  = 8,
   parameter int CNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ev_start,
   input  logic              ev_end,
   input  logic              hit_valid,
   input  logic [COL_W-1:0]  hit_col,
   input  logic [ROW_W-1:0]  hit_row,
   input  logic [TS_W-1:0]   hit_ts,
   output logic              req,
   output logic [WORD_W-1:0] word,
   output logic              hdr_mark,
   output logic              trl_mark
);
   if (TAG_W + COL_W + ROW_W + TS_W != WORD_W) begin : g_bad_layout
      $error("evfr_frame_ctl: hit fields must fill the word beside the tag");
   end
   if (CNT_W < 1 || CNT_W > WORD_W) begin : g_bad_cnt
      $error("evfr_frame_ctl: CNT_W must be 1..WORD_W");
   end

   fr_state_t        state, state_nx;
   wsel_t            sel;
   logic [CNT_W-1:0] evnum;

   always_comb begin
      req      = 1'b0;
      sel      = W_HDR;
      state_nx = state;
      unique case (state)
         ST_IDLE: if (ev_start) begin
            req      = 1'b1;
            sel      = W_HDR;
            state_nx = ST_NUM;
         end
         ST_NUM: begin
            req      = 1'b1;
            sel      = W_NUM;
            state_nx = ST_BODY;
         end
         ST_BODY: if (ev_end) begin
            req      = 1'b1;
            sel      = W_TRL;
            state_nx = ST_IDLE;
         end else if (hit_valid) begin
            req      = 1'b1;
            sel      = W_HIT;
         end
         default: state_nx = ST_IDLE;
      endcase
      if (clr) begin
         req      = 1'b0;
         state_nx = ST_IDLE;
      end
   end

   always_comb begin
      unique case (sel)
         W_HDR:   word = HDR_WORD;
         W_NUM:   word = WORD_W'(evnum);
         W_HIT:   word = {HIT_TAG, hit_col, hit_row, hit_ts};
         default: word = TRL_WORD;
      endcase
      hdr_mark = req && (sel == W_HDR);
      trl_mark = req && (sel == W_TRL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         evnum <= '0;
      end else begin
         state <= state_nx;
         if (clr)           evnum <= '0;
         else if (trl_mark) evnum <= evnum + CNT_W'(1);
      end
   end

   // R8: a header is always followed by a write (the number) unless cleared
   p_num_follows_hdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_mark |=> (clr || (req && !hdr_mark && !trl_mark)));
   // R3: event number advances by one per closed event
   p_evnum_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trl_mark |=> (evnum == $past(evnum) + CNT_W'(1)));
   // R9: clear restarts the count
   p_evnum_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (evnum == '0));
   // R9: nothing requested in a clear cycle
   p_clr_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> !req);
endmodule

// File: rtl/evfr_write_port.sv
module evfr_write_port #(
   parameter int ADDR_W = 16,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              req,
   input  logic [WORD_W-1:0] word,
   input  logic              hdr_mark,
   input  logic              trl_mark,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data,
   output logic [ADDR_W-1:0] last_ptr
);
   if (ADDR_W < 4 || ADDR_W > 24) begin : g_bad_addr
      $error("evfr_write_port: ADDR_W must be 4..24");
   end

   logic [ADDR_W-1:0] wp;
   logic [ADDR_W-1:0] open_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp        <= '0;
         open_addr <= '0;
         last_ptr  <= '0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
      end else begin
         wr_en <= req && !clr;
         if (req) begin
            wr_addr <= wp;
            wr_data <= word;
         end
         if (clr)      wp <= '0;
         else if (req) wp <= wp + ADDR_W'(1);
         if (hdr_mark) open_addr <= wp;
         if (trl_mark) last_ptr  <= open_addr;
      end
   end

   // R6: pointer steps by one per write, wrapping at the top
   p_wp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !clr) |=> (wp == $past(wp) + ADDR_W'(1)));
   // R6: issued write lands at the pre-step pointer
   p_addr_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !clr) |=> (wr_en && wr_addr == $past(wp)));
   // R9: clear returns pointer to zero
   p_wp_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (wp == '0 && !wr_en));
   // R7: pointer published together with the trailer
   p_last_on_trl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trl_mark |=> (last_ptr == $past(open_addr)));
   // R7: pointer holds otherwise
   p_last_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !trl_mark |=> $stable(last_ptr));
endmodule

// File: rtl/hit_event_framer.sv
module hit_event_framer
   import evfr_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int COL_W    = 6,
   parameter int ROW_W    = 6,
   parameter int TS_W     = 8,
   parameter int STAMP_W  = 8,
   parameter int RATE_W   = 2,
   parameter int CNT_W    = 32,
   parameter bit GRAY_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               ev_start,
   input  logic               ev_end,
   input  logic               hit_valid,
   input  logic [COL_W-1:0]   hit_col,
   input  logic [ROW_W-1:0]   hit_row,
   input  logic [TS_W-1:0]    hit_ts,
   input  logic [RATE_W-1:0]  rate_sel,
   output logic               wr_en,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [WORD_W-1:0]  wr_data,
   output logic [ADDR_W-1:0]  last_ptr,
   output logic [STAMP_W-1:0] ts_gray
);
   logic              req;
   logic [WORD_W-1:0] word;
   logic              hdr_mark;
   logic              trl_mark;

   evfr_frame_ctl #(
      .COL_W(COL_W), .ROW_W(ROW_W), .TS_W(TS_W), .CNT_W(CNT_W)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .ev_start(ev_start), .ev_end(ev_end), .hit_valid(hit_valid),
      .hit_col(hit_col), .hit_row(hit_row), .hit_ts(hit_ts),
      .req(req), .word(word), .hdr_mark(hdr_mark), .trl_mark(trl_mark)
   );

   evfr_write_port #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W)
   ) u_port (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .req(req), .word(word), .hdr_mark(hdr_mark), .trl_mark(trl_mark),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .last_ptr(last_ptr)
   );

   evfr_gray_stamp #(
      .STAMP_W(STAMP_W), .RATE_W(RATE_W), .REG_OUT(GRAY_REG)
   ) u_stamp (
      .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .gray_o(ts_gray)
   );
endmodule

// File: tb/hit_event_framer_test.sv
module hit_event_framer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        ev_start = 1'b0;
   logic        ev_end = 1'b0;
   logic        hit_valid = 1'b0;
   logic [5:0]  hit_col = '0;
   logic [5:0]  hit_row = '0;
   logic [7:0]  hit_ts = '0;
   logic [1:0]  rate_sel = '0;
   logic        wr_en;
   logic [15:0] wr_addr;
   logic [31:0] wr_data;
   logic [15:0] last_ptr;
   logic [7:0]  ts_gray;

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [31:0] HDR = 32'hFABEABBA;
   localparam logic [31:0] TRL = 32'hBEEFBEEF;

   // {start,end,hit,exp_en, col6,row6,ts8, pad8, exp_data32}
   localparam logic [63:0] VEC [0:12] = '{
      {1'b0,1'b0,1'b1,1'b0, 6'h01,6'h02,8'h03, 8'h00, 32'h0},
      {1'b0,1'b1,1'b0,1'b0, 6'h00,6'h00,8'h00, 8'h00, 32'h0},
      {1'b1,1'b0,1'b0,1'b1, 6'h00,6'h00,8'h00, 8'h00, HDR},
      {1'b0,1'b0,1'b1,1'b1, 6'h3F,6'h3F,8'hFF, 8'h00, 32'h0000_0000},
      {1'b0,1'b0,1'b1,1'b1, 6'h3F,6'h00,8'hA5, 8'h00, 32'hF0FF_C0A5},
      {1'b0,1'b0,1'b1,1'b1, 6'h00,6'h3F,8'h5A, 8'h00, 32'hF0F0_3F5A},
      {1'b1,1'b0,1'b0,1'b0, 6'h00,6'h00,8'h00, 8'h00, 32'h0},
      {1'b0,1'b0,1'b0,1'b0, 6'h00,6'h00,8'h00, 8'h00, 32'h0},
      {1'b0,1'b1,1'b1,1'b1, 6'h07,6'h07,8'h07, 8'h00, TRL},
      {1'b1,1'b0,1'b0,1'b1, 6'h00,6'h00,8'h00, 8'h00, HDR},
      {1'b0,1'b0,1'b0,1'b1, 6'h00,6'h00,8'h00, 8'h00, 32'h0000_0001},
      {1'b0,1'b0,1'b1,1'b1, 6'h15,6'h2A,8'h33, 8'h00, 32'hF0F5_6A33},
      {1'b0,1'b1,1'b0,1'b1, 6'h00,6'h00,8'h00, 8'h00, TRL}
   };

   hit_event_framer uut (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .ev_start(ev_start), .ev_end(ev_end), .hit_valid(hit_valid),
      .hit_col(hit_col), .hit_row(hit_row), .hit_ts(hit_ts),
      .rate_sel(rate_sel),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .last_ptr(last_ptr), .ts_gray(ts_gray)
   );

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic s, input logic e, input logic h,
                        input logic [5:0] c, input logic [5:0] r,
                        input logic [7:0] t);
      ev_start = s; ev_end = e; hit_valid = h;
      hit_col = c; hit_row = r; hit_ts = t;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      logic [15:0] ea;
      logic [15:0] open_a;
      logic [15:0] exp_last;
      logic [7:0]  prev;
      int          changes;
      bit          bad;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(wr_en == 1'b0 && last_ptr == 16'd0 && ts_gray == 8'd0,
            "R1 reset", {wr_en, last_ptr, ts_gray}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(wr_en == 1'b0 && last_ptr == 16'd0, "R1 first cycle",
            {wr_en, last_ptr}, 32'd0);
      check(ts_gray == 8'd1, "R10 gray after 1 edge", ts_gray, 8'd1);

      // R10: rate 0, gray of edge count
      for (int k = 2; k <= 12; k++) begin
         @(negedge clk);
         check(ts_gray == 8'(k ^ (k >> 1)), "R10 gray rate0", ts_gray,
               8'(k ^ (k >> 1)));
      end
      // R10: rate 2, four single-bit steps in sixteen cycles
      rate_sel = 2'd2;
      @(negedge clk);
      prev = ts_gray; changes = 0; bad = 0;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         if (ts_gray != prev) changes++;
         if ($countones(ts_gray ^ prev) > 1) bad = 1;
         prev = ts_gray;
      end
      check(changes == 4 && !bad, "R10 gray rate2", changes, 4);
      rate_sel = 2'd0;

      // Vector table: R2 R3 R4 R5 R7 R8
      ea = 16'd0; open_a = 16'd0; exp_last = 16'd0;
      for (int i = 0; i < 13; i++) begin
         logic [63:0] v;
         string tag;
         v = VEC[i];
         drive(v[63], v[62], v[61], v[59:54], v[53:48], v[47:40]);
         if (!v[60]) tag = "R8 ignored";
         else if (v[31:0] == HDR) tag = "R2 header";
         else if (v[31:0] == TRL) tag = "R5 trailer";
         else if (v[31:20] == 12'hF0F) tag = "R4 hit";
         else tag = "R3 event number";
         check(wr_en == v[60], tag, wr_en, v[60]);
         if (v[60]) begin
            check(wr_data == v[31:0] && wr_addr == ea, tag,
                  wr_data, v[31:0]);
            if (v[31:0] == HDR) open_a = ea;
            if (v[31:0] == TRL) exp_last = open_a;
            ea = ea + 16'd1;
         end
         check(last_ptr == exp_last, "R7 last pointer", last_ptr, exp_last);
      end

      // R9: clear mid-event
      drive(1'b1, 1'b0, 1'b0, 6'h0, 6'h0, 8'h0);
      check(wr_en && wr_data == HDR && wr_addr == ea, "R2 header pre-clear",
            wr_data, HDR);
      drive(1'b0, 1'b0, 1'b0, 6'h0, 6'h0, 8'h0);
      check(wr_en && wr_data == 32'd2, "R3 third event number", wr_data, 32'd2);
      clr = 1'b1;
      drive(1'b1, 1'b0, 1'b1, 6'h1, 6'h1, 8'h1);
      clr = 1'b0;
      check(wr_en == 1'b0 && last_ptr == exp_last, "R9 clear no write",
            {wr_en, last_ptr}, {1'b0, exp_last});
      drive(1'b0, 1'b0, 1'b1, 6'h2, 6'h2, 8'h2);
      check(wr_en == 1'b0, "R9 event closed by clear", wr_en, 1'b0);
      drive(1'b1, 1'b0, 1'b0, 6'h0, 6'h0, 8'h0);
      check(wr_en && wr_addr == 16'd0 && wr_data == HDR, "R9 restart addr",
            wr_addr, 16'd0);
      drive(1'b0, 1'b0, 1'b0, 6'h0, 6'h0, 8'h0);
      check(wr_en && wr_addr == 16'd1 && wr_data == 32'd0, "R9 number reset",
            wr_data, 32'd0);
      drive(1'b0, 1'b1, 1'b0, 6'h0, 6'h0, 8'h0);
      check(wr_en && wr_data == TRL && last_ptr == 16'd0, "R7 last after clear",
            last_ptr, 16'd0);

      // R6: long event across the top of the buffer
      drive(1'b1, 1'b0, 1'b0, 6'h0, 6'h0, 8'h0);
      check(wr_en && wr_addr == 16'd3 && wr_data == HDR, "R2 wrap header",
            wr_addr, 16'd3);
      drive(1'b0, 1'b0, 1'b0, 6'h0, 6'h0, 8'h0);
      check(wr_en && wr_data == 32'd1, "R3 number after clear", wr_data, 32'd1);
      ev_start = 1'b0; hit_valid = 1'b1;
      hit_col = 6'h2A; hit_row = 6'h15; hit_ts = 8'hC3;
      bad = 0; ea = 16'd5;
      for (int j = 0; j < 65532; j++) begin
         @(negedge clk);
         if (!wr_en || wr_addr != ea || wr_data != 32'hF0FA_95C3) bad = 1;
         if (last_ptr != 16'd0) bad = 1;
         ea = ea + 16'd1;
      end
      check(!bad && wr_addr == 16'd0, "R6 wrap to zero", wr_addr, 16'd0);
      check(last_ptr == 16'd0, "R7 hold during event", last_ptr, 16'd0);
      drive(1'b0, 1'b1, 1'b0, 6'h0, 6'h0, 8'h0);
      check(wr_en && wr_addr == 16'd1 && wr_data == TRL, "R5 trailer after wrap",
            wr_data, TRL);
      check(last_ptr == 16'd3, "R7 last after wrap", last_ptr, 16'd3);

      finish_run();
   end
endmodule